// File: doc/BRIEF.md
# 8-bit Timer/Counter with Compare and Overflow Interrupts

This block is an 8-bit counter that advances on count-enable pulses. A three-bit code chooses where those pulses come from: the system clock divided by a power of two, or rising edges on an external event pin. There are two counting modes. Free-running mode counts up and wraps. Up/down mode ramps from zero to full scale and back, which gives a symmetric pulse-width modulated waveform. On each counting step the new count is compared against a programmable compare value. The block also drives a single waveform output bit according to a selectable action taken on a compare match.

Two sticky flags record events: a wrap event and a compare event. Each flag is masked by its own mask bit and by a global enable input to form an interrupt request. A flag clears when its acknowledge input is pulsed, or when software writes a one to it.

Software reaches the registers through a simple write port and a combinational read port. The address map is:

- 0: control. Bits [2:0] clock source, bits [4:3] match action, bits [6:5] counting mode. Bit 7 reads as zero.
- 1: compare value.
- 2: count.
- 3: mask. Bit 0 is the wrap mask and bit 1 is the compare mask.
- 4: flags. Bit 0 is the wrap flag and bit 1 is the compare flag.

Top module: `tmr8_core`

## Requirements
- R1: After reset every register reads zero, both interrupt requests are low and the waveform output is low.
- R2: The clock-source code selects how often the counter steps. Code 000 stops the counter. Codes 001, 010, 011, 100, 101 and 110 step it once every 1, 8, 32, 64, 128 and 256 clock cycles.
- R3: Writing a different clock-source code restarts the divider. With code 010 the count first changes on the 8th rising clock edge after the write edge. No step happens in a cycle in which control is written.
- R4: Code 111 steps the counter once for each rising edge of `ext_evt`, after two synchronizer stages.
- R5: Mode bits 00, 10 and 11 select free-running mode. The counter counts up from 0xFF to 0x00, and only that step sets flag bit 0.
- R6: Mode bits 01 select up/down mode. The count runs 0x00 up to 0xFF, turns at 0xFF to 0xFE, runs down to 0x00 and turns to 0x01. Only the turn at 0x00 sets flag bit 0. Leaving up/down mode makes the count run upward.
- R7: Flag bit 1 is set by any counting step whose new count equals the compare value.
- R8: `irq_ovf` equals `global_en` AND mask bit 0 AND flag bit 0. `irq_cmp` is formed the same way from bit 1 of the mask and flag.
- R9: A flag is cleared by its acknowledge input or by writing 1 to its bit at address 4. A flag event in the same cycle wins over the clear.
- R10: Writing the count loads the written value in that cycle. That cycle raises no wrap or compare event.
- R11: In free-running mode a compare match applies the action in control bits [4:3] to `wave_out`: 01 toggles it, 10 clears it, 11 sets it and 00 leaves it unchanged.
- R12: In up/down mode with action bits other than 00, a match on an upward step clears `wave_out` and a match on a downward step sets it.
- R13: Control reads back bits [6:0] of the value written. Mask and flags read back in bits [1:0] with the upper bits zero. Addresses 5 to 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data, combinational |
| ext_evt | input | 1 | External event input, asynchronous |
| global_en | input | 1 | Global interrupt enable |
| ack_ovf | input | 1 | Acknowledge, clears the wrap flag |
| ack_cmp | input | 1 | Acknowledge, clears the compare flag |
| irq_ovf | output | 1 | Wrap interrupt request |
| irq_cmp | output | 1 | Compare interrupt request |
| wave_out | output | 1 | Waveform output bit |

## Verification
The bench sweeps every compare value through a match in free-running mode. A design that detected the match on the old count instead of the new one would flag one step late. A design that matched on a count write would raise a spurious flag.

Up/down runs use compare values at 0x00, 0x01, 0xFF and mid-scale. A design that flagged the wrap at the top turn, or that double-counted the end values, would show a shifted sequence or a flag set twice per period. At 0x00 and 0xFF the match can only fall on one direction of travel, so an inverted waveform rule shows up at once.

An acknowledge is placed on the very cycle of a new wrap event. A design that let the clear win would lose that interrupt. The bench also counts the cycles from a clock-source change to the first step. A divider that was not restarted would step early.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

  localparam logic [2:0] ADR_CTRL = 3'd0;
  localparam logic [2:0] ADR_CMP  = 3'd1;
  localparam logic [2:0] ADR_CNT  = 3'd2;
  localparam logic [2:0] ADR_MASK = 3'd3;
  localparam logic [2:0] ADR_FLAG = 3'd4;

  localparam logic [2:0] CS_STOP = 3'b000;
  localparam logic [2:0] CS_EXT  = 3'b111;

  localparam int CTRL_W = 7;

  typedef enum logic [1:0] {
    WG_FREE   = 2'b00,
    WG_UPDOWN = 2'b01,
    WG_RSV2   = 2'b10,
    WG_RSV3   = 2'b11
  } wgm_e;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } act_e;

  typedef struct packed {
    logic [1:0] wgm;
    logic [1:0] act;
    logic [2:0] cs;
  } ctrl_t;

  // log2 of the divide ratio for each prescaled source code
  function automatic int unsigned cs_shift(logic [2:0] cs);
    case (cs)
      3'b010:  return 3;
      3'b011:  return 5;
      3'b100:  return 6;
      3'b101:  return 7;
      3'b110:  return 8;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/tmr8_prescale.sv
module tmr8_prescale
  import tmr8_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] cs,
  input  logic       restart,
  input  logic       ext_in,
  output logic       tick
);

  logic [DIV_W-1:0]     div_q;
  logic [SYNC_STAGES:0] sh_q;
  logic                 ext_rise;
  logic [DIV_W-1:0]     sel_mask;

  function automatic logic [DIV_W-1:0] div_mask(logic [2:0] c);
    logic [DIV_W:0] m;
    m = ((DIV_W+1)'(1) << cs_shift(c)) - (DIV_W+1)'(1);
    return m[DIV_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       div_q <= '0;
    else if (restart) div_q <= '0;
    else              div_q <= div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SYNC_STAGES-1:0], ext_in};
  end

  assign ext_rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
  assign sel_mask = div_mask(cs);

  always_comb begin
    case (cs)
      CS_STOP: tick = 1'b0;
      CS_EXT:  tick = ext_rise;
      default: tick = ((div_q & sel_mask) == sel_mask);
    endcase
  end

endmodule

// File: rtl/tmr8_counter.sv
module tmr8_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         updown,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] cmp_val,
  output logic [W-1:0] cnt,
  output logic         cnt_down,
  output logic         ovf_evt,
  output logic         cmp_evt,
  output logic         cmp_up
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  typedef struct packed {
    logic [W-1:0] v;
    logic         dn;
    logic         wrap;
  } nxt_t;

  function automatic nxt_t advance(logic [W-1:0] c, logic d, logic ud);
    nxt_t r;
    r.v    = c + 1'b1;
    r.dn   = 1'b0;
    r.wrap = 1'b0;
    if (!ud) begin
      r.wrap = (c == TOP);
    end else if (!d) begin
      if (c == TOP) begin
        r.v  = c - 1'b1;
        r.dn = 1'b1;
      end
    end else if (c == '0) begin
      r.wrap = 1'b1;
    end else begin
      r.v  = c - 1'b1;
      r.dn = 1'b1;
    end
    return r;
  endfunction

  nxt_t nx;
  logic step;

  assign nx      = advance(cnt, cnt_down, updown);
  assign step    = tick & ~load;
  assign ovf_evt = step & nx.wrap;
  assign cmp_evt = step & (nx.v == cmp_val);
  assign cmp_up  = ~nx.dn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      cnt_down <= 1'b0;
    end else begin
      if (load) begin
        cnt <= load_val;
      end else if (step) begin
        cnt      <= nx.v;
        cnt_down <= nx.dn;
      end
      if (!updown) cnt_down <= 1'b0;
    end
  end

endmodule

// File: rtl/tmr8_wave.sv
module tmr8_wave
  import tmr8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit,
  input  logic       hit_up,
  input  logic       updown,
  input  logic [1:0] act,
  output logic       wave_q
);

  logic wave_d;

  always_comb begin
    wave_d = wave_q;
    if (hit) begin
      if (updown) begin
        if (act != ACT_HOLD) wave_d = ~hit_up;
      end else begin
        case (act)
          ACT_TOGGLE: wave_d = ~wave_q;
          ACT_CLEAR:  wave_d = 1'b0;
          ACT_SET:    wave_d = 1'b1;
          default:    wave_d = wave_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wave_q <= 1'b0;
    else        wave_q <= wave_d;
  end

endmodule

// File: rtl/tmr8_core.sv
module tmr8_core
  import tmr8_pkg::*;
#(
  parameter int W           = 8,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [2:0]   rd_addr,
  output logic [W-1:0] rd_data,
  input  logic         ext_evt,
  input  logic         global_en,
  input  logic         ack_ovf,
  input  logic         ack_cmp,
  output logic         irq_ovf,
  output logic         irq_cmp,
  output logic         wave_out
);

  ctrl_t        ctrl_q;
  logic [W-1:0] cmp_q;
  logic [1:0]   mask_q;
  logic [1:0]   flag_q;

  // named internal events
  logic         wr_ctrl, wr_cmp, wr_mask, wr_flag, cnt_load;
  logic         cs_restart, pre_tick, tick_w, updown;
  logic [W-1:0] cnt_w;
  logic         cnt_down, ovf_evt, cmp_evt, cmp_up;
  logic [1:0]   flag_set, flag_clr;

  assign wr_ctrl  = wr_en && (wr_addr == ADR_CTRL);
  assign wr_cmp   = wr_en && (wr_addr == ADR_CMP);
  assign cnt_load = wr_en && (wr_addr == ADR_CNT);
  assign wr_mask  = wr_en && (wr_addr == ADR_MASK);
  assign wr_flag  = wr_en && (wr_addr == ADR_FLAG);

  assign cs_restart = wr_ctrl && (wr_data[2:0] != ctrl_q.cs);
  assign tick_w     = pre_tick & ~wr_ctrl;
  assign updown     = (ctrl_q.wgm == WG_UPDOWN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cmp_q  <= '0;
      mask_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
      if (wr_cmp)  cmp_q  <= wr_data;
      if (wr_mask) mask_q <= wr_data[1:0];
    end
  end

  tmr8_prescale #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs      (ctrl_q.cs),
    .restart (cs_restart),
    .ext_in  (ext_evt),
    .tick    (pre_tick)
  );

  tmr8_counter #(.W(W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_w),
    .updown   (updown),
    .load     (cnt_load),
    .load_val (wr_data),
    .cmp_val  (cmp_q),
    .cnt      (cnt_w),
    .cnt_down (cnt_down),
    .ovf_evt  (ovf_evt),
    .cmp_evt  (cmp_evt),
    .cmp_up   (cmp_up)
  );

  tmr8_wave u_wave (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit    (cmp_evt),
    .hit_up (cmp_up),
    .updown (updown),
    .act    (ctrl_q.act),
    .wave_q (wave_out)
  );

  // flags: a new event outranks any clear in the same cycle
  assign flag_set = {cmp_evt, ovf_evt};
  assign flag_clr = {ack_cmp, ack_ovf} | (wr_flag ? wr_data[1:0] : 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_set | (flag_q & ~flag_clr);
  end

  assign irq_ovf = global_en & mask_q[0] & flag_q[0];
  assign irq_cmp = global_en & mask_q[1] & flag_q[1];

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADR_CTRL: rd_data[CTRL_W-1:0] = ctrl_q;
      ADR_CMP:  rd_data = cmp_q;
      ADR_CNT:  rd_data = cnt_w;
      ADR_MASK: rd_data[1:0] = mask_q;
      ADR_FLAG: rd_data[1:0] = flag_q;
      default:  rd_data = '0;
    endcase
  end

endmodule

// File: rtl/tmr8_chk.sv
module tmr8_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         global_en,
  input logic         ack_ovf,
  input logic         irq_ovf,
  input logic         irq_cmp,
  input logic         ovf_evt,
  input logic         cmp_evt,
  input logic         cmp_up,
  input logic         updown,
  input logic [1:0]   act,
  input logic [2:0]   cs,
  input logic [W-1:0] cnt,
  input logic         cnt_load,
  input logic [W-1:0] load_val,
  input logic [1:0]   flag,
  input logic         wave
);

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ovf || irq_cmp) |-> global_en);

  // R9
  ovf_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> flag[0]);

  // R7
  cmp_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_evt |=> flag[1]);

  // R9
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ovf && !ovf_evt) |=> !flag[0]);

  // R10
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |=> (cnt == $past(load_val)));

  // R5
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !updown) |=> (cnt == '0));

  // R6
  bottom_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && updown) |=> (cnt == W'(1)));

  // R2
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs == 3'b000 && !cnt_load) |=> $stable(cnt));

  // R12
  pwm_wave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_evt && updown && act != 2'b00) |=> (wave == !$past(cmp_up)));

endmodule

bind tmr8_core tmr8_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .global_en (global_en),
  .ack_ovf   (ack_ovf),
  .irq_ovf   (irq_ovf),
  .irq_cmp   (irq_cmp),
  .ovf_evt   (ovf_evt),
  .cmp_evt   (cmp_evt),
  .cmp_up    (cmp_up),
  .updown    (updown),
  .act       (ctrl_q.act),
  .cs        (ctrl_q.cs),
  .cnt       (cnt_w),
  .cnt_load  (cnt_load),
  .load_val  (wr_data),
  .flag      (flag_q),
  .wave      (wave_out)
);

// File: tb/tb_tmr8_core.sv
`timescale 1ns/1ps
module tb_tmr8_core;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = 3'd2;
  logic [7:0] rd_data;
  logic       ext_evt = 1'b0;
  logic       global_en = 1'b0;
  logic       ack_ovf = 1'b0;
  logic       ack_cmp = 1'b0;
  logic       irq_ovf, irq_cmp, wave_out;

  always #4 clk = ~clk;

  tmr8_core dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ext_evt(ext_evt), .global_en(global_en),
    .ack_ovf(ack_ovf), .ack_cmp(ack_cmp), .irq_ovf(irq_ovf), .irq_cmp(irq_cmp),
    .wave_out(wave_out)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  bit auto_ack = 0;
  bit ge_toggle = 0;

  // expected state, derived from the requirements
  logic [6:0] m_ctrl = '0;
  logic [7:0] m_cmp = '0, m_cnt = '0, m_div = '0;
  logic       m_down = 0, m_wave = 0;
  logic [1:0] m_mask = '0, m_flag = '0;
  logic [2:0] m_sh = '0;

  function automatic int div_of(logic [2:0] cs);
    case (cs)
      3'd1: return 1;   3'd2: return 8;   3'd3: return 32;
      3'd4: return 64;  3'd5: return 128; 3'd6: return 256;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(string req);
    logic [2:0] cs;
    logic ud, wc, wl, wf, tk, ev_o, ev_c, up;
    logic [1:0] act, clr;
    logic [7:0] n_cnt, n_div;
    logic n_down, n_wave;
    int d;
    cs  = m_ctrl[2:0];
    act = m_ctrl[4:3];
    ud  = (m_ctrl[6:5] == 2'b01);
    wc  = wr_en && wr_addr == 3'd0;
    wl  = wr_en && wr_addr == 3'd2;
    wf  = wr_en && wr_addr == 3'd4;
    d   = div_of(cs);
    if (wc || cs == 3'd0) tk = 0;
    else if (cs == 3'd7) tk = m_sh[1] && !m_sh[2];
    else tk = ((int'(m_div) % d) == d - 1);
    n_div = (wc && wr_data[2:0] != cs) ? 8'd0 : m_div + 8'd1;
    n_cnt = m_cnt; n_down = m_down; n_wave = m_wave;
    ev_o = 0; ev_c = 0; up = 1;
    if (wl) n_cnt = wr_data;
    else if (tk) begin
      if (!ud) begin
        n_cnt = m_cnt + 8'd1; ev_o = (m_cnt == 8'hFF); n_down = 0;
      end else if (!m_down) begin
        if (m_cnt == 8'hFF) begin n_cnt = 8'hFE; n_down = 1; end
        else n_cnt = m_cnt + 8'd1;
      end else begin
        if (m_cnt == 8'h00) begin n_cnt = 8'h01; n_down = 0; ev_o = 1; end
        else n_cnt = m_cnt - 8'd1;
      end
      ev_c = (n_cnt == m_cmp);
      up = !n_down;
    end
    if (!ud) n_down = 0;
    if (ev_c) begin
      if (ud) begin
        if (act != 2'b00) n_wave = !up;
      end else begin
        case (act)
          2'b01: n_wave = !m_wave;
          2'b10: n_wave = 0;
          2'b11: n_wave = 1;
          default: n_wave = m_wave;
        endcase
      end
    end
    clr = {ack_cmp, ack_ovf} | (wf ? wr_data[1:0] : 2'b00);
    @(posedge clk);
    m_flag = {ev_c, ev_o} | (m_flag & ~clr);
    if (wc) m_ctrl = wr_data[6:0];
    if (wr_en && wr_addr == 3'd1) m_cmp = wr_data;
    if (wr_en && wr_addr == 3'd3) m_mask = wr_data[1:0];
    m_cnt = n_cnt; m_down = n_down; m_wave = n_wave; m_div = n_div;
    m_sh = {m_sh[1:0], ext_evt};
    @(negedge clk);
    wr_en = 0; ack_ovf = 0; ack_cmp = 0;
    if (ge_toggle) global_en = ~global_en;
    rd_addr = 3'd2; #1;
    chk(req, "count", int'(rd_data), int'(m_cnt));
    rd_addr = 3'd4; #1;
    chk(req, "flags", int'(rd_data), int'(m_flag));
    rd_addr = 3'd2;
    chk(req, "irq_ovf", int'(irq_ovf), int'(global_en & m_mask[0] & m_flag[0]));
    chk(req, "irq_cmp", int'(irq_cmp), int'(global_en & m_mask[1] & m_flag[1]));
    chk(req, "wave", int'(wave_out), int'(m_wave));
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] v, string req);
    wr_en = 1; wr_addr = a; wr_data = v;
    step(req);
  endtask

  task automatic run(int n, string req);
    for (int i = 0; i < n; i++) begin
      if (auto_ack) begin ack_ovf = irq_ovf; ack_cmp = irq_cmp; end
      step(req);
    end
  endtask

  task automatic read_chk(logic [2:0] a, int exp, string req);
    rd_addr = a; #1;
    chk(req, "read", int'(rd_data), exp);
    rd_addr = 3'd2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int k_first;
    logic [7:0] pwm_cmps [5];
    pwm_cmps[0] = 8'h00; pwm_cmps[1] = 8'h01; pwm_cmps[2] = 8'h80;
    pwm_cmps[3] = 8'hFE; pwm_cmps[4] = 8'hFF;
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int a = 0; a < 5; a++) read_chk(3'(a), 0, "R1");
    chk("R1", "irq_ovf", int'(irq_ovf), 0);
    chk("R1", "irq_cmp", int'(irq_cmp), 0);
    chk("R1", "wave", int'(wave_out), 0);
    rst_n = 1;

    // R13: read-back layout
    wr(3'd0, 8'hF8, "R13");
    wr(3'd3, 8'hFF, "R13");
    wr(3'd1, 8'hA5, "R13");
    read_chk(3'd0, 'h78, "R13");
    read_chk(3'd3, 'h03, "R13");
    read_chk(3'd1, 'hA5, "R13");
    for (int a = 5; a < 8; a++) read_chk(3'(a), 0, "R13");
    wr(3'd0, 8'h00, "R13");

    // R2: each prescaled rate, then stopped
    global_en = 1; auto_ack = 1;
    for (int c = 1; c <= 6; c++) begin
      wr(3'd0, 8'(c), "R2");
      wr(3'd2, 8'h00, "R2");
      run(600, "R2");
    end
    wr(3'd0, 8'h00, "R2");
    run(40, "R2");

    // R3: divider restarts on a source change
    wr(3'd2, 8'h10, "R3");
    wr(3'd0, 8'h02, "R3");
    k_first = 0;
    for (int k = 1; k <= 20; k++) begin
      step("R3");
      if (k_first == 0 && m_cnt != 8'h10) k_first = k;
    end
    chk("R3", "edges to first step", k_first, 8);
    run(50, "R3");

    // R7: sweep every compare value through a match in free-running mode
    wr(3'd0, 8'h09, "R7");
    wr(3'd3, 8'h03, "R7");
    auto_ack = 0;
    for (int c = 0; c < 256; c++) begin
      wr(3'd1, 8'(c), "R7");
      wr(3'd4, 8'h03, "R9");
      wr(3'd2, 8'(c - 3), "R10");
      run(6, "R7");
    end
    auto_ack = 1;
    wr(3'd1, 8'h40, "R5");
    run(600, "R5");

    // R11: other match actions in free-running mode
    wr(3'd0, 8'h11, "R11"); run(600, "R11");
    wr(3'd0, 8'h19, "R11"); run(600, "R11");
    wr(3'd0, 8'h01, "R11"); run(300, "R11");

    // R8: gating by global enable and masks
    auto_ack = 0; ge_toggle = 1;
    wr(3'd0, 8'h09, "R8");
    wr(3'd3, 8'h01, "R8"); run(300, "R8");
    wr(3'd3, 8'h02, "R8"); run(300, "R8");
    wr(3'd3, 8'h00, "R8"); run(300, "R8");
    ge_toggle = 0; global_en = 1;
    wr(3'd3, 8'h03, "R8");
    wr(3'd4, 8'h03, "R8");

    // R6 / R12: up/down mode across end and mid compare values
    auto_ack = 1;
    for (int i = 0; i < 5; i++) begin
      wr(3'd0, 8'h29, "R6");
      wr(3'd1, pwm_cmps[i], "R6");
      wr(3'd2, 8'h00, "R6");
      run(1100, "R6");
      wr(3'd0, 8'h31, "R12");
      run(1100, "R12");
    end
    wr(3'd0, 8'h29, "R6");
    wr(3'd2, 8'h00, "R6");
    run(300, "R6");
    wr(3'd0, 8'h09, "R6");
    run(300, "R6");

    // R9: event beats acknowledge; write-one-to-clear
    auto_ack = 0;
    wr(3'd4, 8'h03, "R9");
    wr(3'd2, 8'hFE, "R9");
    step("R9");
    ack_ovf = 1;
    step("R9");
    chk("R9", "flag kept by new event", int'(m_flag[0]), 1);
    ack_ovf = 1;
    step("R9");
    wr(3'd2, 8'hFF, "R9");
    step("R9");
    wr(3'd4, 8'h01, "R9");

    // R10: count write to the compare value raises nothing
    wr(3'd0, 8'h00, "R10");
    wr(3'd1, 8'h40, "R10");
    wr(3'd4, 8'h03, "R10");
    wr(3'd2, 8'h40, "R10");
    run(4, "R10");
    wr(3'd2, 8'hFF, "R10");
    wr(3'd0, 8'h09, "R10");
    wr(3'd2, 8'hFF, "R10");
    run(3, "R10");

    // R4: external rising edges of varying widths
    wr(3'd0, 8'h0F, "R4");
    wr(3'd2, 8'hF0, "R4");
    wr(3'd1, 8'hF8, "R4");
    for (int p = 1; p <= 40; p++) begin
      ext_evt = 1;
      for (int h = 0; h < 1 + p % 4; h++) step("R4");
      ext_evt = 0;
      for (int l = 0; l < 1 + p % 3; l++) step("R4");
    end
    run(4, "R4");
    read_chk(3'd2, (8'hF0 + 40) & 8'hFF, "R4");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule